// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Cell

This block is the output cell of a programmable-array-logic device. It has a small AND plane of its own. Each product term picks any mix of true and complemented literals from the array inputs and from the cell's own feedback signal. Several of these terms are ORed into a sum. A two-bit mode setting chooses how that sum reaches the pin: straight through or captured in a D flip-flop, and in true or inverted sense.

Three further product terms have fixed roles:
- One clears the flip-flop asynchronously.
- One presets the flip-flop on the next clock edge.
- One enables the tri-state pin driver.

A feedback line goes back into the AND plane, so the cell can hold state or use its pin as an input. In registered modes the feedback is the flip-flop output. In combinational modes it is the level seen on the pin.

Top module: `pal_macrocell`

## Requirements
- R1: Each product term is the AND of the literals it selects. The literal vector is {feedback, array_in}, with the feedback at index N_IN. For term j and literal k, connection bit j*2*(N_IN+1)+2k selects the true literal and the bit one above it selects the complement. A term that selects nothing is 1. A term that selects both senses of one literal is 0.
- R2: The sum is the OR of the first N_SUM product terms. Term N_SUM is the clear term, N_SUM+1 is the preset term and N_SUM+2 is the enable term.
- R3: cfg_mode bit 0 selects registered (1) or combinational (0). Bit 1 inverts the pin value. In combinational modes pin_o equals the sum XOR bit 1, with no clock delay.
- R4: In registered modes the flip-flop loads the sum on each rising clock edge, and pin_o equals the flip-flop value XOR cfg_mode bit 1. A change of inputs between edges does not reach the pin until the next edge.
- R5: While the clear term is 1, the flip-flop reads 0 at once, without waiting for a clock edge. It keeps reading 0 across clock edges even when the preset term is also 1.
- R6: When the preset term is 1 and the clear term is 0, the flip-flop becomes 1 at the next rising edge and not before.
- R7: The synchronous reset rst clears the flip-flop at a rising edge and does not act between edges.
- R8: In registered modes fb_out is the flip-flop value in true sense, whatever the polarity bit. In combinational modes fb_out equals pin_i.
- R9: pin_oe equals the enable product term. When it is 0 the pin is treated as an input and pin_i still feeds back in combinational modes.
- R10: A registered cell whose only sum term selects the complemented feedback toggles on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flip-flop |
| cfg_mode | input | 2 | Bit 0 registered, bit 1 inverted |
| cfg_conn | input | (N_SUM+3)*2*(N_IN+1) | Literal-select bits, two per literal per term |
| array_in | input | N_IN | Array input signals |
| pin_i | input | 1 | Level observed on the pin |
| pin_o | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Tri-state driver enable |
| fb_out | output | 1 | Feedback signal returned to the array |

## Verification
The hardest case to reach from the ports is a clear that arrives between clock edges while a preset request is also pending. The bench first loads a 1 into the flip-flop. It then routes the clear and preset terms to two separate array inputs. It raises the clear input in mid-cycle and checks the pin before any edge arrives. It then holds both inputs high across an edge and confirms the clear still wins. Finally it drops only the clear input and watches the preset act at the next edge and not earlier.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    MODE_COMB_HI = 2'b00,
    MODE_REG_HI  = 2'b01,
    MODE_COMB_LO = 2'b10,
    MODE_REG_LO  = 2'b11
  } pal_mode_e;

  // product terms beyond the sum: clear, preset, enable
  localparam int CTRL_TERMS = 3;
  localparam int OFS_CLR = 0;
  localparam int OFS_PRE = 1;
  localparam int OFS_OE  = 2;
endpackage

// File: rtl/pal_and_array.sv
module pal_and_array #(
  parameter int N_LIT  = 5,
  parameter int N_TERM = 6
) (
  input  logic [N_LIT-1:0]          lit,
  input  logic [N_TERM*2*N_LIT-1:0] conn,
  output logic [N_TERM-1:0]         term
);
  localparam int TERM_W = 2 * N_LIT;

  for (genvar j = 0; j < N_TERM; j++) begin : g_term
    logic [N_LIT-1:0] pass;
    for (genvar k = 0; k < N_LIT; k++) begin : g_lit
      // a selected true literal blocks when low, a selected complement blocks when high
      assign pass[k] = ~(conn[j*TERM_W + 2*k]     & ~lit[k]) &
                       ~(conn[j*TERM_W + 2*k + 1] &  lit[k]);
    end
    assign term[j] = &pass;
  end
endmodule

// File: rtl/pal_cell_ff.sv
module pal_cell_ff (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pre,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr)      q <= 1'b0;
    else if (rst) q <= 1'b0;
    else if (pre) q <= 1'b1;
    else          q <= d;
  end
endmodule

// File: rtl/pal_out_select.sv
module pal_out_select (
  input  logic [1:0] mode,
  input  logic       sum,
  input  logic       q,
  input  logic       pin_i,
  input  logic       oe,
  output logic       pin_o,
  output logic       pin_oe,
  output logic       fb
);
  logic use_reg;
  logic src;

  always_comb begin
    use_reg = mode[0];
    src     = use_reg ? q : sum;
    pin_o   = src ^ mode[1];
    pin_oe  = oe;
    fb      = use_reg ? q : pin_i;
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int N_IN  = 4,
  parameter int N_SUM = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [1:0]                          cfg_mode,
  input  logic [(N_SUM+3)*2*(N_IN+1)-1:0]     cfg_conn,
  input  logic [N_IN-1:0]                     array_in,
  input  logic                                pin_i,
  output logic                                pin_o,
  output logic                                pin_oe,
  output logic                                fb_out
);
  import pal_pkg::*;

  localparam int N_LIT  = N_IN + 1;
  localparam int N_TERM = N_SUM + CTRL_TERMS;

  logic [N_LIT-1:0]  lit;
  logic [N_TERM-1:0] terms;
  logic              sum_w;
  logic              ar_t;
  logic              sp_t;
  logic              oe_t;
  logic              q_r;
  logic              fb_w;

  assign lit = {fb_w, array_in};

  pal_and_array #(.N_LIT(N_LIT), .N_TERM(N_TERM)) u_array (
    .lit  (lit),
    .conn (cfg_conn),
    .term (terms)
  );

  assign sum_w = |terms[N_SUM-1:0];
  assign ar_t  = terms[N_SUM + OFS_CLR];
  assign sp_t  = terms[N_SUM + OFS_PRE];
  assign oe_t  = terms[N_SUM + OFS_OE];

  pal_cell_ff u_ff (
    .clk (clk),
    .rst (rst),
    .clr (ar_t),
    .pre (sp_t),
    .d   (sum_w),
    .q   (q_r)
  );

  pal_out_select u_out (
    .mode   (cfg_mode),
    .sum    (sum_w),
    .q      (q_r),
    .pin_i  (pin_i),
    .oe     (oe_t),
    .pin_o  (pin_o),
    .pin_oe (pin_oe),
    .fb     (fb_w)
  );

  assign fb_out = fb_w;
endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       sum_w,
  input logic       ar_t,
  input logic       sp_t,
  input logic       q_r,
  input logic       pin_i,
  input logic       pin_o,
  input logic       fb_out
);
  // R5
  clr_holds_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ar_t |-> !q_r);

  // R6
  preset_sets_one_chk: assert property (@(posedge clk) disable iff (rst)
    (sp_t && !ar_t) |=> (q_r || ar_t));

  // R4
  reg_loads_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (!sp_t && !ar_t) |=> (q_r == $past(sum_w) || ar_t));

  // R3
  comb_pin_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode[0] |-> (pin_o == (sum_w ^ cfg_mode[1])));

  // R8
  fb_reg_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_mode[0] |-> (fb_out == q_r));

  // R8
  fb_comb_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode[0] |-> (fb_out == pin_i));
endmodule

bind pal_macrocell pal_macrocell_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_mode (cfg_mode),
  .sum_w    (sum_w),
  .ar_t     (ar_t),
  .sp_t     (sp_t),
  .q_r      (q_r),
  .pin_i    (pin_i),
  .pin_o    (pin_o),
  .fb_out   (fb_out)
);

// File: tb/tb_pal_macrocell.sv
module tb_pal_macrocell;
  localparam int N_IN   = 4;
  localparam int N_SUM  = 3;
  localparam int N_LIT  = N_IN + 1;
  localparam int N_TERM = N_SUM + 3;
  localparam int CFG_W  = N_TERM * 2 * N_LIT;
  localparam int T_CLR  = N_SUM;
  localparam int T_PRE  = N_SUM + 1;
  localparam int T_OE   = N_SUM + 2;
  localparam int L_FB   = N_IN;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       mode = 2'b01;
  logic [CFG_W-1:0] conn = '0;
  logic [N_IN-1:0]  ain = '0;
  logic             pin_i = 1'b0;
  logic             pin_o, pin_oe, fb_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pal_macrocell #(.N_IN(N_IN), .N_SUM(N_SUM)) dut (
    .clk(clk), .rst(rst), .cfg_mode(mode), .cfg_conn(conn),
    .array_in(ain), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_empty(input int j);
    for (int k = 0; k < 2*N_LIT; k++) conn[j*2*N_LIT + k] = 1'b0;
  endtask

  task automatic t_zero(input int j);
    t_empty(j);
    conn[j*2*N_LIT] = 1'b1;
    conn[j*2*N_LIT + 1] = 1'b1;
  endtask

  task automatic t_lit(input int j, input int k, input bit comp);
    conn[j*2*N_LIT + 2*k + int'(comp)] = 1'b1;
  endtask

  task automatic mid();
    @(posedge clk); #2;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic test_reset();
    rst = 1'b1;
    tick(); tick();
    chk("R7 reset clears", pin_o, 1'b0);
    chk("R9 empty enable term", pin_oe, 1'b1);
    mid(); rst = 1'b0;
  endtask

  task automatic test_and_terms();
    mode = 2'b00;
    t_empty(0); t_lit(0, 0, 0); t_lit(0, 1, 1);
    t_zero(1); t_zero(2);
    for (int v = 0; v < 16; v++) begin
      mid(); ain = v[3:0]; #2;
      chk("R1 and term", pin_o, ain[0] & ~ain[1]);
    end
    t_empty(0); mid(); #2;
    chk("R1 empty term is one", pin_o, 1'b1);
  endtask

  task automatic test_sum();
    mode = 2'b00;
    t_empty(0); t_lit(0, 0, 0); t_lit(0, 1, 0);
    t_empty(1); t_lit(1, 2, 0);
    t_empty(2); t_lit(2, 3, 1);
    for (int v = 0; v < 16; v++) begin
      mid(); ain = v[3:0]; #2;
      chk("R2 sum of terms", pin_o, (ain[0] & ain[1]) | ain[2] | ~ain[3]);
    end
    mode = 2'b10;
    t_empty(0); t_lit(0, 0, 0); t_zero(1); t_zero(2);
    mid(); ain = 4'b0001; #2;
    chk("R3 inverted comb", pin_o, 1'b0);
    mid(); ain = 4'b0000; #2;
    chk("R3 inverted comb", pin_o, 1'b1);
  endtask

  task automatic test_registered();
    mode = 2'b01;
    t_empty(0); t_lit(0, 0, 0); t_zero(1); t_zero(2);
    mid(); ain = 4'b0000;
    tick();
    chk("R4 reg low", pin_o, 1'b0);
    #5 ain = 4'b0001; #2;
    chk("R4 no change before edge", pin_o, 1'b0);
    tick();
    chk("R4 loaded at edge", pin_o, 1'b1);
    mode = 2'b11; #1;
    chk("R3 reg inverted", pin_o, 1'b0);
    mode = 2'b01;
    // synchronous reset acts only at the edge
    #3 rst = 1'b1; #2;
    chk("R7 no clear before edge", pin_o, 1'b1);
    tick();
    chk("R7 cleared at edge", pin_o, 1'b0);
    #2 rst = 1'b0;
  endtask

  task automatic test_clear_preset();
    mode = 2'b01;
    t_empty(0); t_lit(0, 0, 0);
    mid(); ain = 4'b0001;
    tick();
    chk("R4 set up one", pin_o, 1'b1);
    #3;
    t_empty(T_CLR); t_lit(T_CLR, 2, 0);
    t_empty(T_PRE); t_lit(T_PRE, 3, 0);
    #2 ain = 4'b1101; #2;
    chk("R5 async clear mid cycle", pin_o, 1'b0);
    tick();
    chk("R5 clear beats preset", pin_o, 1'b0);
    #3 ain = 4'b1000; #2;
    chk("R6 no preset before edge", pin_o, 1'b0);
    tick();
    chk("R6 preset at edge", pin_o, 1'b1);
    #3 t_zero(T_CLR); t_zero(T_PRE); ain = 4'b0000;
    tick();
    chk("R4 back to sum", pin_o, 1'b0);
  endtask

  task automatic test_toggle();
    logic exp;
    mode = 2'b01;
    t_empty(0); t_lit(0, L_FB, 1); t_zero(1); t_zero(2);
    mid();
    exp = pin_o;
    for (int n = 0; n < 4; n++) begin
      tick();
      exp = ~exp;
      chk("R10 toggle", pin_o, exp);
      chk("R8 fb from flop", fb_out, pin_o);
    end
    mode = 2'b11; #2;
    chk("R8 fb true sense", fb_out, ~pin_o);
  endtask

  task automatic test_comb_fb();
    mode = 2'b00;
    t_empty(0); t_lit(0, L_FB, 0); t_zero(1); t_zero(2);
    t_zero(T_OE);
    mid(); #1;
    chk("R9 enable off", pin_oe, 1'b0);
    pin_i = 1'b1; #2;
    chk("R8 pin fed back", fb_out, 1'b1);
    chk("R9 input pin reaches sum", pin_o, 1'b1);
    mid(); pin_i = 1'b0; #2;
    chk("R8 pin fed back", fb_out, 1'b0);
    t_empty(T_OE); t_lit(T_OE, 1, 0);
    mid(); ain = 4'b0010; #2;
    chk("R9 enable term on", pin_oe, 1'b1);
    mid(); ain = 4'b0000; #2;
    chk("R9 enable term off", pin_oe, 1'b0);
  endtask

  initial begin
    t_zero(0); t_zero(1); t_zero(2);
    t_zero(T_CLR); t_zero(T_PRE); t_empty(T_OE);
    test_reset();
    test_and_terms();
    test_sum();
    test_registered();
    test_clear_preset();
    test_toggle();
    test_comb_fb();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule